// File: doc/BRIEF.md
# Programmable Bus Wait-State Controller

This block sets the number of bus-clock cycles each memory access occupies and then steps through that access. The requester presents a one-cycle request strobe together with a region class (special-function space, on-chip memory, or external space behind one of four chip selects), a chip-select index and a flag that marks an external access as multiplexed. The block answers with a busy level, a phase counter that numbers the cycles of the access, and a done pulse in the last cycle.

The length comes from a fixed priority. Special-function space is always two cycles. Multiplexed external accesses are always three. Otherwise a global slow-down bit, when set, forces two cycles on every access and masks the per-chip-select bits. When the global bit is clear, on-chip memory takes one cycle and a separate-bus external access takes one or two cycles, as the fast bit of its chip select selects. The global bit sits behind a write guard: it can only be written while a key bit in a protect register is set.

Register writes use a small write port. Address 0 is the mode register, with the global slow-down bit in bit 0. Address 1 holds the chip-select fast bits, with bit n for chip select n. Address 2 is the protect register, with the key in bit 1. Writes to address 3 have no effect. The block does no address decoding, no data transfer and no clock generation.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset, busy, done, phase and cfg_err are all 0, and the global bit, all fast bits and the key are 0. An on-chip access then takes 1 cycle and a separate-bus external access takes 2 cycles. Reset asserts asynchronously, and the block leaves reset on the second rising clock edge after rst_n goes high.
- R2: An access with region code 2'b00 (special-function space) takes 2 cycles, whatever the global bit and the fast bits hold.
- R3: An access with region code 2'b01 (on-chip memory) takes 1 cycle when the global bit is 0 and 2 cycles when it is 1.
- R4: When the global bit is 1, a separate-bus external access (region code 2'b10 or 2'b11, mux_bus=0) takes 2 cycles and the fast bits are ignored.
- R5: When the global bit is 0, a separate-bus external access takes 1 cycle if fast bit cs_sel is 1 and 2 cycles if it is 0.
- R6: An external access with mux_bus=1 always takes 3 cycles.
- R7: An accepted multiplexed external access whose chip-select fast bit is 1 sets cfg_err. cfg_err stays set until reset.
- R8: A write to address 0 changes the global bit only while the key (bit 1 of address 2) is 1, and is dropped otherwise. Clearing the key leaves the global bit unchanged. Writes to address 1 are never guarded.
- R9: The length is taken from the register values that hold just before the accepting clock edge. A write at the same edge as the accept, or during the access, does not change that access.
- R10: A request is accepted only while busy is 0. From the next cycle, busy is 1 and phase counts 1, 2, … up to the length. done is 1 only in the final cycle. busy falls on the following edge. A request while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request strobe |
| region | input | 2 | Region code: 00 special-function, 01 on-chip, 1x external |
| cs_sel | input | 2 | Chip-select index of an external access |
| mux_bus | input | 1 | External access uses the multiplexed bus |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Register write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final cycle of the access |
| phase | output | 2 | Cycle number within the access, 0 when idle |
| cfg_err | output | 1 | Sticky multiplexed-with-fast-bit error |

## Verification
The bench builds the block with its default parameters: four chip selects, a two-bit length and phase, and lengths of 1, 2 and 3 cycles. With these values every chip-select fast bit, both bus kinds and all three lengths can be reached. Random register writes, some of them hitting the guarded register with the key both set and clear, are mixed with random accesses so that every branch of the priority order is taken. Directed sequences cover writes at the accepting edge, writes during an access, requests while busy and the sticky error across a reset.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [1:0] {
    RG_SFR  = 2'b00,
    RG_INT  = 2'b01,
    RG_EXT  = 2'b10,
    RG_EXT2 = 2'b11
  } region_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_FAST = 2'd1;
  localparam logic [1:0] ADDR_KEY  = 2'd2;

  localparam int KEY_BIT  = 1;
  localparam int MODE_BIT = 0;

endpackage

// File: rtl/bwc_regs.sv
module bwc_regs
  import bwc_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [NUM_CS-1:0] wdata,
  output logic              gwait,
  output logic [NUM_CS-1:0] cs_fast
);

  logic              gwait_q, gwait_d, gwait_en;
  logic [NUM_CS-1:0] fast_q, fast_d;
  logic              fast_en;
  logic              key_q, key_d, key_en;

  always_comb begin
    gwait_en = we && (addr == ADDR_MODE) && key_q;
    fast_en  = we && (addr == ADDR_FAST);
    key_en   = we && (addr == ADDR_KEY);
    gwait_d  = wdata[MODE_BIT];
    fast_d   = wdata;
    key_d    = wdata[KEY_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gwait_q <= 1'b0;
      fast_q  <= '0;
      key_q   <= 1'b0;
    end else begin
      if (gwait_en) gwait_q <= gwait_d;
      if (fast_en)  fast_q  <= fast_d;
      if (key_en)   key_q   <= key_d;
    end
  end

  assign gwait   = gwait_q;
  assign cs_fast = fast_q;

endmodule

// File: rtl/bwc_len.sv
module bwc_len
  import bwc_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int CSW      = 2,
  parameter int LEN_W    = 2,
  parameter int FAST_LEN = 1,
  parameter int SLOW_LEN = 2,
  parameter int MUX_LEN  = 3,
  parameter int SFR_LEN  = 2
) (
  input  logic [1:0]        region,
  input  logic [CSW-1:0]    cs_sel,
  input  logic              mux_bus,
  input  logic              gwait,
  input  logic [NUM_CS-1:0] cs_fast,
  output logic [LEN_W-1:0]  len,
  output logic              conflict
);

  region_e rg;
  logic    sel_fast;

  always_comb begin
    rg       = region_e'(region);
    sel_fast = cs_fast[cs_sel];
    conflict = 1'b0;
    unique case (rg)
      RG_SFR: len = LEN_W'(SFR_LEN);
      RG_INT: len = gwait ? LEN_W'(SLOW_LEN) : LEN_W'(FAST_LEN);
      default: begin
        if (mux_bus) begin
          len      = LEN_W'(MUX_LEN);
          conflict = sel_fast;
        end else if (gwait) begin
          len = LEN_W'(SLOW_LEN);
        end else begin
          len = sel_fast ? LEN_W'(FAST_LEN) : LEN_W'(SLOW_LEN);
        end
      end
    endcase
  end

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LEN_W-1:0] len_in,
  input  logic             conflict_in,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] phase,
  output logic             cfg_err
);

  logic             busy_q, busy_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             err_q, err_d;
  logic             accept, last;

  always_comb begin
    accept = req && !busy_q;
    last   = busy_q && (cnt_q == len_q);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    err_d  = err_q | (accept & conflict_in);
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = LEN_W'(1);
      len_d  = len_in;
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (accept) len_q <= len_d;
      err_q  <= err_d;
    end
  end

  assign busy    = busy_q;
  assign done    = last;
  assign phase   = cnt_q;
  assign cfg_err = err_q;

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl #(
  parameter int NUM_CS      = 4,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FAST_LEN    = 1,
  parameter int SLOW_LEN    = 2,
  parameter int MUX_LEN     = 3,
  parameter int SFR_LEN     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic [1:0]                region,
  input  logic [$clog2(NUM_CS)-1:0] cs_sel,
  input  logic                      mux_bus,
  input  logic                      reg_we,
  input  logic [1:0]                reg_addr,
  input  logic [NUM_CS-1:0]         reg_wdata,
  output logic                      busy,
  output logic                      done,
  output logic [LEN_W-1:0]          phase,
  output logic                      cfg_err
);

  localparam int CSW = $clog2(NUM_CS);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic              gwait;
  logic [NUM_CS-1:0] cs_fast;
  logic [LEN_W-1:0]  acc_len;
  logic              acc_conflict;

  bwc_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .gwait   (gwait),
    .cs_fast (cs_fast)
  );

  bwc_len #(
    .NUM_CS   (NUM_CS),
    .CSW      (CSW),
    .LEN_W    (LEN_W),
    .FAST_LEN (FAST_LEN),
    .SLOW_LEN (SLOW_LEN),
    .MUX_LEN  (MUX_LEN),
    .SFR_LEN  (SFR_LEN)
  ) u_len (
    .region   (region),
    .cs_sel   (cs_sel),
    .mux_bus  (mux_bus),
    .gwait    (gwait),
    .cs_fast  (cs_fast),
    .len      (acc_len),
    .conflict (acc_conflict)
  );

  bwc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req         (req),
    .len_in      (acc_len),
    .conflict_in (acc_conflict),
    .busy        (busy),
    .done        (done),
    .phase       (phase),
    .cfg_err     (cfg_err)
  );

endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
  parameter int LEN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic [1:0]       region,
  input logic             mux_bus,
  input logic             busy,
  input logic             done,
  input logic [LEN_W-1:0] phase,
  input logic             cfg_err
);

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (busy && phase == LEN_W'(1)));

  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r10_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && phase == LEN_W'($past(phase) + LEN_W'(1))));

  a_r2_sfr_two: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && region == 2'b00) |=> (!done ##1 done));

  a_r6_mux_three: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && region[1] && mux_bus) |=> (!done ##1 !done ##1 done));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

bind bus_wait_ctrl bwc_checker #(.LEN_W(LEN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .req     (req),
  .region  (region),
  .mux_bus (mux_bus),
  .busy    (busy),
  .done    (done),
  .phase   (phase),
  .cfg_err (cfg_err)
);

// File: tb/tb_bus_wait_ctrl.sv
module tb_bus_wait_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req;
  logic [1:0] region;
  logic [1:0] cs_sel;
  logic       mux_bus;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [3:0] reg_wdata;
  logic       busy, done, cfg_err;
  logic [1:0] phase;

  int n_chk = 0;
  int n_err = 0;

  logic       m_gw;
  logic [3:0] m_fast;
  logic       m_key;
  logic       m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wait_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .region(region), .cs_sel(cs_sel),
    .mux_bus(mux_bus), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .done(done), .phase(phase),
    .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] rg, input logic [1:0] cs, input logic mx);
    if (rg == 2'b00) return 2;
    if (rg == 2'b01) return m_gw ? 2 : 1;
    if (mx) return 3;
    if (m_gw) return 2;
    return m_fast[cs] ? 1 : 2;
  endfunction

  function automatic string len_tag(input logic [1:0] rg, input logic mx);
    if (rg == 2'b00) return "R2";
    if (rg == 2'b01) return "R3";
    if (mx) return "R6";
    return m_gw ? "R4" : "R5";
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req = 0; region = 0; cs_sel = 0; mux_bus = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    m_gw = 0; m_fast = 0; m_key = 0; m_err = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && phase == 0 && !cfg_err, "R1 reset outputs",
          {busy, done, phase, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a == 2'd0 && m_key) m_gw = d[0];
    if (a == 2'd1) m_fast = d;
    if (a == 2'd2) m_key = d[1];
  endtask

  task automatic access(input logic [1:0] rg, input logic [1:0] cs, input logic mx,
                        input string tag);
    int e, n;
    e = exp_len(rg, cs, mx);
    if (rg[1] && mx && m_fast[cs]) m_err = 1;
    @(negedge clk);
    req = 1; region = rg; cs_sel = cs; mux_bus = mx;
    @(negedge clk);
    req = 0;
    n = 1;
    check(busy && phase == 1, "R10 first phase", phase, 1);
    while (!done && n < 8) begin
      @(negedge clk);
      n++;
      check(busy && phase == n[1:0], "R10 phase count", phase, n);
    end
    check(n == e, tag, n, e);
    @(negedge clk);
    check(!busy && !done, "R10 idle after done", busy, 0);
    check(cfg_err == m_err, "R7 cfg_err", cfg_err, m_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    do_reset();
    // R1 defaults
    access(2'b01, 2'd0, 0, "R1 on-chip default");
    access(2'b10, 2'd2, 0, "R1 external default");
    access(2'b00, 2'd0, 0, "R2 sfr");
    // R8 guarded write dropped without key
    wr(2'd0, 4'b0001);
    access(2'b01, 2'd0, 0, "R8 write dropped, R3 still 1");
    wr(2'd2, 4'b0010);
    wr(2'd0, 4'b0001);
    access(2'b01, 2'd0, 0, "R3 slow on-chip");
    access(2'b00, 2'd1, 1, "R2 sfr with global");
    wr(2'd1, 4'b1111);
    access(2'b10, 2'd1, 0, "R4 fast bits ignored");
    access(2'b11, 2'd3, 1, "R6 mux with conflict R7");
    // R8 clearing key keeps value
    wr(2'd2, 4'b0000);
    access(2'b01, 2'd0, 0, "R8 key cleared, value kept");
    wr(2'd2, 4'b0010);
    wr(2'd0, 4'b0000);
    access(2'b10, 2'd3, 0, "R5 fast cs3");
    wr(2'd1, 4'b0000);
    access(2'b10, 2'd0, 0, "R5 slow cs0");
    // R9 write during access, R10 request while busy ignored
    @(negedge clk);
    req = 1; region = 2'b10; cs_sel = 0; mux_bus = 0;
    @(negedge clk);
    check(busy && phase == 1, "R9 in access", phase, 1);
    reg_we = 1; reg_addr = 2'd1; reg_wdata = 4'b0001;
    @(negedge clk);
    reg_we = 0; req = 0; m_fast = 4'b0001;
    check(done && phase == 2, "R9 length kept during write", phase, 2);
    @(negedge clk);
    check(!busy, "R10 request while busy ignored", busy, 0);
    // R9 same-edge write and accept
    @(negedge clk);
    req = 1; region = 2'b10; cs_sel = 0; mux_bus = 0;
    reg_we = 1; reg_addr = 2'd1; reg_wdata = 4'b0000;
    @(negedge clk);
    req = 0; reg_we = 0; m_fast = 0;
    check(done && phase == 1, "R9 same-edge write uses old value", phase, 1);
    @(negedge clk);
    access(2'b10, 2'd0, 0, "R9 new value applies next");
    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) < 4)
        wr(2'($urandom_range(0, 3)), 4'($urandom));
      else begin
        logic [1:0] rg, cs;
        logic mx;
        rg = 2'($urandom); cs = 2'($urandom); mx = 1'($urandom);
        access(rg, cs, mx, len_tag(rg, mx));
      end
    end
    // R7 cleared by reset only
    do_reset();
    check(!cfg_err, "R7 cleared by reset", cfg_err, 0);
    access(2'b01, 2'd0, 0, "R1 after second reset");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule